// File: doc/BRIEF.md
# Eight-Bit General-Purpose I/O Port with Pullup Gating

This block is one slice of general-purpose I/O. A small synchronous register bus sets three registers: an output data latch, a direction mask and a pullup enable mask. From these registers the block drives three signals to each pad: output enable, output value and pullup request. The block samples the pad input levels through a synchronizer. On a data-register read it returns, for each bit, either the latch or the synchronized pin level. The direction bit of that pin makes the choice.

Software sets a bit as an output by setting its direction bit. It can preload the latch at any time, and the preloaded value reaches the pin only once the bit turns into an output. A pullup requested on an input pin is released to the pad automatically while that pin is an output. The bus is a plain register port with no handshake: a write completes on the clock edge that samples the strobe, and read data is returned in the same cycle as the read strobe.

Top module: `gpio_port`

## Requirements
- R1: After reset the latch, direction and pullup registers all hold zero, and pad_oe, pad_out and pad_pu are all zero, so every pin is an input.
- R2: A write to offset 0x00 loads the latch whatever the direction bits hold. A latch bit whose direction is 0 does not reach pad_oe.
- R3: A read of offset 0x00 returns, for each bit, the latch bit when direction is 1 and the synchronized pin bit when direction is 0.
- R4: pad_pu for each bit equals pullup bit AND NOT direction bit. It follows the registers with no added cycle, so it is never 1 while pad_oe is 1 for that bit.
- R5: pad_oe equals the direction register and pad_out equals the latch, bit for bit.
- R6: The direction register (offset 0x04) and the pullup register (offset 0x0D) read back their stored values, and each of their bits can be set independently.
- R7: A change on pad_in shows in a data read of an input bit after exactly two rising clock edges and not after one.
- R8: A read of any offset other than 0x00, 0x04 or 0x0D returns zero, and bus_rdata is zero whenever bus_rd is low.
- R9: A write to an unmapped offset changes no register, as seen at the pad outputs and on readback.
- R10: A write takes effect on the clock edge that samples bus_wr. A read in the same cycle as a write to the same offset returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, valid in the strobe cycle |
| pad_in | input | 8 | Pad input levels (asynchronous) |
| pad_oe | output | 8 | Per-bit pad output enable |
| pad_out | output | 8 | Per-bit pad output value |
| pad_pu | output | 8 | Per-bit pullup request after gating |

## Verification
Two functions can fall in the same cycle. A register write and a read of that same register is one case. A change of direction and the pullup gating that depends on it is the other. The bench provokes both in directed steps and at random, issuing read and write strobes together on one offset. It expects the pre-write value on bus_rdata, and it expects the new value on the next read. It also flips direction bits while pullups are enabled and checks after the edge that pad_pu has dropped to zero on exactly those bits in the same cycle in which pad_oe rose.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_DATA = 2'd1,
    SEL_DIR  = 2'd2,
    SEL_PU   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_pkg::*;
#(
  parameter int W        = 8,
  parameter int AW       = 8,
  parameter int DATA_OFS = 0,
  parameter int DIR_OFS  = 4,
  parameter int PU_OFS   = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr,
  input  logic [W-1:0]  wdata,
  output reg_sel_e      sel,
  output logic [W-1:0]  latch_q,
  output logic [W-1:0]  dir_q,
  output logic [W-1:0]  pu_q
);
  localparam logic [AW-1:0] A_DATA = AW'(DATA_OFS);
  localparam logic [AW-1:0] A_DIR  = AW'(DIR_OFS);
  localparam logic [AW-1:0] A_PU   = AW'(PU_OFS);

  always_comb begin
    unique case (addr)
      A_DATA:  sel = SEL_DATA;
      A_DIR:   sel = SEL_DIR;
      A_PU:    sel = SEL_PU;
      default: sel = SEL_NONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      dir_q   <= '0;
      pu_q    <= '0;
    end else if (wr) begin
      case (sel)
        SEL_DATA: latch_q <= wdata;
        SEL_DIR:  dir_q   <= wdata;
        SEL_PU:   pu_q    <= wdata;
        default:  ;
      endcase
    end
  end

  // R2: latch takes data regardless of direction
  a_r2_latch_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == SEL_DATA) |=> latch_q == $past(wdata));

  // R9: unmapped writes leave all state untouched
  a_r9_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == SEL_NONE) |=> ($stable(latch_q) && $stable(dir_q) && $stable(pu_q)));

  // R10: no write strobe, no register change
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> ($stable(latch_q) && $stable(dir_q) && $stable(pu_q)));
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= '0;
      else if (s == 0) stg[s] <= d;
      else stg[s] <= stg[(s == 0) ? 0 : s-1];
    end
  end

  assign q = stg[STAGES-1];

  if (STAGES >= 2) begin : g_chk
    // R7: each stage carries the previous one forward by one edge
    a_r7_stage_shift: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> stg[STAGES-1] == $past(stg[STAGES-2]));
  end
endmodule

// File: rtl/gpio_readback.sv
module gpio_readback
  import gpio_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rd,
  input  reg_sel_e     sel,
  input  logic [W-1:0] latch_q,
  input  logic [W-1:0] dir_q,
  input  logic [W-1:0] pu_q,
  input  logic [W-1:0] pin_s,
  output logic [W-1:0] rdata,
  output logic [W-1:0] pu_eff
);
  logic [W-1:0] data_view;

  for (genvar b = 0; b < W; b++) begin : g_bit
    assign data_view[b] = dir_q[b] ? latch_q[b] : pin_s[b];
    assign pu_eff[b]    = pu_q[b] & ~dir_q[b];
  end

  always_comb begin
    rdata = '0;
    if (rd) begin
      case (sel)
        SEL_DATA: rdata = data_view;
        SEL_DIR:  rdata = dir_q;
        SEL_PU:   rdata = pu_q;
        default:  rdata = '0;
      endcase
    end
  end

  // R8: unmapped or idle reads give zero
  a_r8_unmapped_read: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd || sel == SEL_NONE) |-> rdata == '0);
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int W           = 8,
  parameter int AW          = 8,
  parameter int DATA_OFS    = 0,
  parameter int DIR_OFS     = 4,
  parameter int PU_OFS      = 13,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [W-1:0]  bus_wdata,
  input  logic          bus_rd,
  output logic [W-1:0]  bus_rdata,
  input  logic [W-1:0]  pad_in,
  output logic [W-1:0]  pad_oe,
  output logic [W-1:0]  pad_out,
  output logic [W-1:0]  pad_pu
);
  reg_sel_e     sel;
  logic [W-1:0] latch_q, dir_q, pu_q, pin_s;

  gpio_regfile #(.W(W), .AW(AW), .DATA_OFS(DATA_OFS), .DIR_OFS(DIR_OFS), .PU_OFS(PU_OFS)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata),
    .sel(sel), .latch_q(latch_q), .dir_q(dir_q), .pu_q(pu_q)
  );

  gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pin_s)
  );

  gpio_readback #(.W(W)) u_rb (
    .clk(clk), .rst_n(rst_n), .rd(bus_rd), .sel(sel), .latch_q(latch_q),
    .dir_q(dir_q), .pu_q(pu_q), .pin_s(pin_s), .rdata(bus_rdata), .pu_eff(pad_pu)
  );

  assign pad_oe  = dir_q;
  assign pad_out = latch_q;

  // R4: pullup never requested on a driven pin
  a_r4_pu_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu & pad_oe) == '0);

  // R3: an output bit reads back its latch value
  a_r3_out_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == AW'(DATA_OFS)) |-> ((bus_rdata & pad_oe) == (pad_out & pad_oe)));
endmodule

// File: tb/tb_gpio_port.sv
module tb_gpio_port;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic [7:0] pad_in = '0;
  logic [7:0] pad_oe, pad_out, pad_pu;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] m_lat = '0, m_dir = '0, m_pu = '0, m_s1 = '0, m_s2 = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
  );

  function automatic logic [7:0] exp_rd(logic rd, logic [7:0] a);
    if (!rd) return 8'h00;
    case (a)
      8'h00:   return (m_dir & m_lat) | (~m_dir & m_s2);
      8'h04:   return m_dir;
      8'h0D:   return m_pu;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic pads(string req);
    chk({req, " pad_oe"}, pad_oe, m_dir);
    chk({req, " pad_out"}, pad_out, m_lat);
    chk({req, " pad_pu"}, pad_pu, m_pu & ~m_dir);
  endtask

  // one bus cycle: drive at negedge, check read in-cycle, then advance model
  task automatic step(string req, logic [7:0] a, logic wr, logic [7:0] wd,
                      logic rd, logic [7:0] pin);
    bus_addr = a; bus_wr = wr; bus_wdata = wd; bus_rd = rd; pad_in = pin;
    #1;
    if (rd) chk(req, bus_rdata, exp_rd(rd, a));
    @(posedge clk);
    m_s2 = m_s1; m_s1 = pin;
    if (wr) begin
      case (a)
        8'h00: m_lat = wd;
        8'h04: m_dir = wd;
        8'h0D: m_pu  = wd;
        default: ;
      endcase
    end
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] pin_now;
    void'($urandom(32'd1234));
    #(CLK_PERIOD*2 + 2);
    // R1: reset state at pads
    pads("R1");
    @(negedge clk); rst_n = 1'b1;
    step("R1 dir", 8'h04, 0, 0, 1, 8'h00);
    step("R1 pu",  8'h0D, 0, 0, 1, 8'h00);

    // R6: independent bits of pullup and direction
    step("R6", 8'h0D, 1, 8'hA5, 0, 8'h00);
    step("R6 pu", 8'h0D, 0, 0, 1, 8'h00);
    pads("R4");
    step("R6", 8'h04, 1, 8'h0F, 0, 8'h00);
    step("R6 dir", 8'h04, 0, 0, 1, 8'h00);
    // R4: direction rose on low nibble, pullups there dropped in same cycle
    pads("R4 gating");
    chk("R4 no pu on output", pad_pu & pad_oe, 8'h00);

    // R2: latch written while bits are inputs; R5 pads follow
    step("R2", 8'h00, 1, 8'h3C, 0, 8'hF0);
    pads("R2 R5");
    // R3: mixed readback
    step("R3", 8'h00, 0, 0, 1, 8'hF0);
    step("R3", 8'h00, 0, 0, 1, 8'hF0);

    // R7: pin latency exactly two edges
    step("R7 set", 8'h00, 0, 0, 0, 8'h0F);
    chk("R7 one edge", bus_rdata, 8'h00);
    bus_rd = 1'b1; #1;
    chk("R7 one edge old", bus_rdata & 8'hF0, 8'hF0);
    bus_rd = 1'b0;
    step("R7 hold", 8'h00, 0, 0, 0, 8'h0F);
    bus_rd = 1'b1; #1;
    chk("R7 two edges new", bus_rdata & 8'hF0, 8'h00);
    bus_rd = 1'b0;
    m_s1 = 8'h0F; m_s2 = 8'h0F;

    // R10: read and write same offset in one cycle return old value
    step("R10 same cycle", 8'h04, 1, 8'hFF, 1, 8'h0F);
    step("R10 after", 8'h04, 0, 0, 1, 8'h0F);
    step("R10 data same cycle", 8'h00, 1, 8'h99, 1, 8'h0F);
    step("R10 data after", 8'h00, 0, 0, 1, 8'h0F);

    // R8 / R9: unmapped offsets
    step("R9", 8'h01, 1, 8'h00, 1, 8'h0F);
    step("R9", 8'h0C, 1, 8'h00, 1, 8'h0F);
    step("R8", 8'hFF, 0, 0, 1, 8'h0F);
    pads("R9 unchanged");
    step("R9 dir", 8'h04, 0, 0, 1, 8'h0F);
    step("R9 pu", 8'h0D, 0, 0, 1, 8'h0F);
    step("R8 idle", 8'h00, 0, 0, 0, 8'h0F);
    chk("R8 rd low", bus_rdata, 8'h00);

    // random mix covering R2 R3 R4 R5 R6 R8 R9 R10
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] a;
      int pick;
      pick = $urandom_range(0, 3);
      case (pick)
        0: a = 8'h00;
        1: a = 8'h04;
        2: a = 8'h0D;
        default: a = 8'($urandom);
      endcase
      pin_now = 8'($urandom);
      step("R3 R6 R8 random", a, 1'($urandom), 8'($urandom), 1'($urandom), pin_now);
      pads("R4 R5 random");
    end
    finish_run();
  end
endmodule